// File: doc/BRIEF.md
# Gated Two-Stage SD Card Clock Divider

The block derives a card clock and a companion high-speed clock from one source clock. The card clock is divided in two cascaded stages: a power-of-two prefix stage selected by a 3-bit code, then a post stage of 2 or 4. The high-speed clock is the output of the prefix stage alone. One configuration word holds both divide codes and two stop bits, one for each clock. It can be written whole. It can also be stopped or restarted by single-cycle pulses that change only the stop bits.

Each write is checked against the ten legal divide combinations and their stop patterns. A rejected write raises a one-cycle error flag and leaves the stored word unchanged. Internally, a free-running phase counter drives every divided output, so each output is a register bit with an exact 50% duty cycle. A new configuration is applied only when this counter wraps, which is a period boundary common to every legal ratio. The undivided high-speed clock is the source clock passed through a latch-based gate.

Top module: `sd_clkdiv_top`

## Requirements
- R1: The word holds the prefix code in bits [4:2] and the post code in bits [1:0]. The card clock period is 2^prefix × (post code 1 ? 4 : 2) source cycles, with equal high and low time, for prefix 0..4. Bits outside [9:8] and [4:0] are not stored and read back as zero.
- R2: When its stop bit is clear, the high-speed clock runs at the source rate for prefix 0 and at half the source rate for prefix 1. When its stop bit is set, it stays low.
- R3: In a running setting, the high-speed stop bit (bit 9) is set exactly when prefix ≥ 2, and the card stop bit (bit 8) is 0. Apart from the fully stopped pattern (both bits set), any other stop pattern makes a write illegal.
- R4: A write with prefix above 4, or with post code 2 or 3, is rejected. err_o is high for exactly the one cycle after the write, and the stored word does not change.
- R5: A disable pulse sets both stop bits and keeps the divide codes. Both output clocks then stay low.
- R6: An enable pulse writes the running stop pattern that belongs to the stored prefix code.
- R7: enabled_o is high exactly when both stored stop bits are 0.
- R8: After reset the word reads 0x300, err_o and enabled_o are low, and both clocks are low.
- R9: A stored change reaches the outputs only at the next wrap of the 64-cycle phase counter. The counter restarts at reset, and the first wrap happens on the 64th rising edge after reset is released. The card clock is low right after each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | REG_W | Configuration word to write |
| en_req_i | input | 1 | Pulse: restore the running stop pattern |
| dis_req_i | input | 1 | Pulse: set both stop bits |
| rd_data_o | output | REG_W | Stored configuration word |
| err_o | output | 1 | One-cycle flag for a rejected write |
| enabled_o | output | 1 | Both stop bits clear |
| card_clk_o | output | 1 | Divided card clock |
| hs_clk_o | output | 1 | High-speed clock after the prefix stage |

## Verification
The stored word is visible on rd_data_o on the cycle after any write, enable or disable pulse. A wrongly accepted or wrongly altered word therefore shows up at once. A wrong active divide setting only shows on the clock outputs after the next counter wrap, which is at most 64 cycles later. The bench therefore waits past one wrap and then counts rising edges and high samples over a 128-cycle window. In that window, a wrong ratio, a wrong duty cycle or a wrong gate state changes the counts.

// File: rtl/sd_clkdiv_pkg.sv
package sd_clkdiv_pkg;

   // field placement inside the configuration word (decoded by software)
   localparam int PFX_LSB       = 2;
   localparam int PFX_W         = 3;
   localparam int POST_LSB      = 0;
   localparam int POST_W        = 2;
   localparam int CARD_STOP_BIT = 8;
   localparam int HS_STOP_BIT   = 9;
   localparam int WORD_MIN_W    = HS_STOP_BIT + 1;

   typedef struct packed {
      logic             hs_stop;
      logic             card_stop;
      logic [PFX_W-1:0] pfx;
      logic             post;
   } sd_cfg_t;

   localparam sd_cfg_t CFG_RESET = '{hs_stop: 1'b1, card_stop: 1'b1, pfx: '0, post: 1'b0};

   // high-speed stop bit required for a running setting with this prefix
   function automatic logic hs_stop_for(input logic [PFX_W-1:0] pfx, input int hs_max);
      return (int'(pfx) > hs_max);
   endfunction

endpackage

// File: rtl/sd_clkdiv_cfg.sv
module sd_clkdiv_cfg
   import sd_clkdiv_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int MAX_PFX    = 4,
   parameter int HS_MAX_PFX = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             en_req_i,
   input  logic             dis_req_i,
   output sd_cfg_t          cfg_o,
   output logic [REG_W-1:0] rd_data_o,
   output logic             err_o
);

   sd_cfg_t           cfg_q;
   logic              err_q;
   logic [PFX_W-1:0]  w_pfx;
   logic [POST_W-1:0] w_post;
   logic              w_hs, w_card;
   logic              fields_ok, stops_ok;
   sd_cfg_t           w_cfg;

   assign w_pfx  = wr_data_i[PFX_LSB +: PFX_W];
   assign w_post = wr_data_i[POST_LSB +: POST_W];
   assign w_hs   = wr_data_i[HS_STOP_BIT];
   assign w_card = wr_data_i[CARD_STOP_BIT];

   always_comb begin
      fields_ok = (int'(w_pfx) <= MAX_PFX) && (w_post < POST_W'(2));
      stops_ok  = (w_hs && w_card) ||
                  (!w_card && (w_hs == hs_stop_for(w_pfx, HS_MAX_PFX)));
      w_cfg     = '{hs_stop: w_hs, card_stop: w_card, pfx: w_pfx, post: w_post[0]};
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= CFG_RESET;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (wr_en_i) begin
            if (fields_ok && stops_ok) cfg_q <= w_cfg;
            else                       err_q <= 1'b1;
         end else if (dis_req_i) begin
            cfg_q.hs_stop   <= 1'b1;
            cfg_q.card_stop <= 1'b1;
         end else if (en_req_i) begin
            cfg_q.hs_stop   <= hs_stop_for(cfg_q.pfx, HS_MAX_PFX);
            cfg_q.card_stop <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data_o                           = '0;
      rd_data_o[HS_STOP_BIT]              = cfg_q.hs_stop;
      rd_data_o[CARD_STOP_BIT]            = cfg_q.card_stop;
      rd_data_o[PFX_LSB +: PFX_W]         = cfg_q.pfx;
      rd_data_o[POST_LSB +: POST_W]       = {1'b0, cfg_q.post};
   end

   assign cfg_o = cfg_q;
   assign err_o = err_q;

   // R4: a rejected write leaves the word as it was
   p_keep_on_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (cfg_q == $past(cfg_q)));

   // R5: disable sets both stops and keeps the divide codes
   p_disable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dis_req_i && !wr_en_i) |=> (cfg_q.hs_stop && cfg_q.card_stop &&
                                   cfg_q.pfx == $past(cfg_q.pfx) && cfg_q.post == $past(cfg_q.post)));

   // R6: enable installs the running pattern of the stored prefix
   p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_req_i && !dis_req_i && !wr_en_i) |=>
         (!cfg_q.card_stop && cfg_q.hs_stop == (int'(cfg_q.pfx) > HS_MAX_PFX)));

   // R3: the stored stop pattern is always a legal one
   p_legal_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.hs_stop && cfg_q.card_stop) ||
      (!cfg_q.card_stop && cfg_q.hs_stop == (int'(cfg_q.pfx) > HS_MAX_PFX)));

endmodule

// File: rtl/sd_clkdiv_core.sv
module sd_clkdiv_core
   import sd_clkdiv_pkg::*;
#(
   parameter int MAX_PFX    = 4,
   parameter int HS_MAX_PFX = 1
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  sd_cfg_t cfg_i,
   output logic    card_o,
   output logic    hs_div_o,
   output logic    hs_pass_o
);

   localparam int PHASE_W = MAX_PFX + 2;
   localparam int IDX_W   = $clog2(PHASE_W);

   logic [PHASE_W-1:0] phase_q, phase_nx;
   sd_cfg_t            act_q, act_nx;
   logic               wrap;
   logic [IDX_W-1:0]   card_idx, hs_idx;
   logic               card_nx, hs_div_nx, hs_pass_nx;
   logic               card_q, hs_div_q, hs_pass_q;

   assign wrap     = &phase_q;
   assign phase_nx = phase_q + 1'b1;
   assign act_nx   = wrap ? cfg_i : act_q;

   always_comb begin
      card_idx   = IDX_W'(act_nx.pfx) + IDX_W'(act_nx.post);
      hs_idx     = IDX_W'(act_nx.pfx) - IDX_W'(1);
      card_nx    = !act_nx.card_stop && phase_nx[card_idx];
      hs_div_nx  = !act_nx.hs_stop && (act_nx.pfx != '0) &&
                   (int'(act_nx.pfx) <= HS_MAX_PFX) && phase_nx[hs_idx];
      hs_pass_nx = !act_nx.hs_stop && (act_nx.pfx == '0);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q   <= '0;
         act_q     <= CFG_RESET;
         card_q    <= 1'b0;
         hs_div_q  <= 1'b0;
         hs_pass_q <= 1'b0;
      end else begin
         phase_q   <= phase_nx;
         act_q     <= act_nx;
         card_q    <= card_nx;
         hs_div_q  <= hs_div_nx;
         hs_pass_q <= hs_pass_nx;
      end
   end

   assign card_o    = card_q;
   assign hs_div_o  = hs_div_q;
   assign hs_pass_o = hs_pass_q;

   // R9: the active setting moves only across a counter wrap
   p_apply_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q != $past(act_q)) |-> $past(wrap));

   // R9: each new common period begins with the card clock low
   p_card_low_after_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wrap) |-> !card_q);

   // R2: the divided and pass-through high-speed paths never run together
   p_hs_one_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({hs_div_q, hs_pass_q}));

endmodule

// File: rtl/sd_clkdiv_gate.sv
module sd_clkdiv_gate #(
   parameter bit USE_LATCH = 1'b1
) (
   input  logic clk_i,
   input  logic en_i,
   output logic gclk_o
);

   logic en_hold;

   generate
      if (USE_LATCH) begin : g_latch
         always_latch begin
            if (!clk_i) en_hold = en_i;
         end
      end else begin : g_negflop
         always_ff @(negedge clk_i) en_hold <= en_i;
      end
   endgenerate

   assign gclk_o = clk_i & en_hold;

endmodule

// File: rtl/sd_clkdiv_top.sv
module sd_clkdiv_top
   import sd_clkdiv_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int MAX_PFX    = 4,
   parameter int HS_MAX_PFX = 1,
   parameter bit USE_LATCH  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             en_req_i,
   input  logic             dis_req_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic             err_o,
   output logic             enabled_o,
   output logic             card_clk_o,
   output logic             hs_clk_o
);

   generate
      if (REG_W < WORD_MIN_W) begin : g_chk_w
         $error("REG_W too small for the stop bits");
      end
      if (MAX_PFX < 1 || MAX_PFX >= (1 << PFX_W)) begin : g_chk_pfx
         $error("MAX_PFX out of the prefix code range");
      end
      if (HS_MAX_PFX < 0 || HS_MAX_PFX > MAX_PFX) begin : g_chk_hs
         $error("HS_MAX_PFX must lie within 0..MAX_PFX");
      end
   endgenerate

   sd_cfg_t cfg;
   logic    hs_div, hs_pass, hs_gated;

   sd_clkdiv_cfg #(.REG_W(REG_W), .MAX_PFX(MAX_PFX), .HS_MAX_PFX(HS_MAX_PFX)) i_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .en_req_i  (en_req_i),
      .dis_req_i (dis_req_i),
      .cfg_o     (cfg),
      .rd_data_o (rd_data_o),
      .err_o     (err_o)
   );

   sd_clkdiv_core #(.MAX_PFX(MAX_PFX), .HS_MAX_PFX(HS_MAX_PFX)) i_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_i     (cfg),
      .card_o    (card_clk_o),
      .hs_div_o  (hs_div),
      .hs_pass_o (hs_pass)
   );

   sd_clkdiv_gate #(.USE_LATCH(USE_LATCH)) i_gate (
      .clk_i  (clk_i),
      .en_i   (hs_pass),
      .gclk_o (hs_gated)
   );

   assign hs_clk_o  = hs_div | hs_gated;
   assign enabled_o = !cfg.hs_stop && !cfg.card_stop;

   // R7: status follows the stored stop bits
   p_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enabled_o |-> (rd_data_o[HS_STOP_BIT] == 1'b0 && rd_data_o[CARD_STOP_BIT] == 1'b0));

endmodule

// File: tb/test_sd_clkdiv_top.sv
module test_sd_clkdiv_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         en_req = 1'b0;
   logic         dis_req = 1'b0;
   logic [W-1:0] rd_data;
   logic         err, enabled, card_clk, hs_clk;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      int           rises;
      int           hs_hi;
      logic [W-1:0] word;
      logic         en;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   bit   mon_busy = 1'b0;

   always #4 clk = ~clk;

   sd_clkdiv_top i_sd_clkdiv_top (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .en_req_i   (en_req),
      .dis_req_i  (dis_req),
      .rd_data_o  (rd_data),
      .err_o      (err),
      .enabled_o  (enabled),
      .card_clk_o (card_clk),
      .hs_clk_o   (hs_clk)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation, waits past a wrap, counts over 128 cycles
   initial begin
      exp_t e;
      int   rises, card_hi, hs_hi;
      logic prev;
      forever begin
         wait (exp_q.size() > 0);
         mon_busy = 1'b1;
         e = exp_q.pop_front();
         repeat (70) @(posedge clk);
         #1;
         prev = card_clk; rises = 0; card_hi = 0; hs_hi = 0;
         for (int i = 0; i < 128; i++) begin
            @(posedge clk); #1;
            if (card_clk && !prev) rises++;
            if (card_clk) card_hi++;
            if (hs_clk) hs_hi++;
            prev = card_clk;
         end
         chk({e.tag, " card rises (R1)"}, rises, e.rises);
         chk({e.tag, " card high samples (R1)"}, card_hi, (e.rises == 0) ? 0 : 64);
         chk({e.tag, " hs high samples (R2)"}, hs_hi, e.hs_hi);
         chk({e.tag, " word"}, rd_data, e.word);
         chk({e.tag, " enabled (R7)"}, enabled, e.en);
         mon_busy = 1'b0;
      end
   end

   // driver tasks
   task automatic expect_out(input int rises, input int hs_hi, input logic [W-1:0] word,
                             input logic en, input string tag);
      exp_t e;
      e.rises = rises; e.hs_hi = hs_hi; e.word = word; e.en = en; e.tag = tag;
      exp_q.push_back(e);
      #1;
      wait (exp_q.size() == 0 && !mon_busy);
   endtask

   task automatic write_word(input logic [W-1:0] d, input logic bad, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(posedge clk); #1;
      chk({tag, " err pulse"}, err, bad);
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk); #1;
      chk({tag, " err one cycle (R4)"}, err, 1'b0);
   endtask

   task automatic pulse(input bit dis, input logic [W-1:0] word, input string tag);
      @(negedge clk);
      if (dis) dis_req = 1'b1; else en_req = 1'b1;
      @(posedge clk); #1;
      chk(tag, rd_data, word);
      @(negedge clk);
      dis_req = 1'b0; en_req = 1'b0;
   endtask

   initial begin
      int hi;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;                       // edge 1 after release
      chk("R8 word after reset", rd_data, 16'h0300);
      chk("R8 err after reset", err, 1'b0);
      chk("R8 enabled after reset", enabled, 1'b0);
      chk("R8 card low", card_clk, 1'b0);
      chk("R8 hs low", hs_clk, 1'b0);

      // R9: written at edge 2, applied only at the wrap on edge 64
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h0000;
      @(posedge clk); #1;                       // edge 2
      @(negedge clk);
      wr_en = 1'b0;
      hi = 0;
      for (int k = 3; k <= 64; k++) begin
         @(posedge clk); #1;
         if (card_clk || hs_clk) hi++;
      end
      chk("R9 outputs held until wrap", hi, 0);
      @(posedge clk); #1;                       // edge 65
      chk("R9 card rises after wrap", card_clk, 1'b1);

      expect_out(64, 128, 16'h0000, 1'b1, "R1 pfx0 post0");
      write_word(16'h0001, 1'b0, "R1 write 0x001");
      expect_out(32, 128, 16'h0001, 1'b1, "R1 pfx0 post1");
      write_word(16'hF004, 1'b0, "R1 write with spare bits");
      expect_out(32, 64, 16'h0004, 1'b1, "R2 pfx1 post0");
      write_word(16'h0005, 1'b0, "R1 write 0x005");
      expect_out(16, 64, 16'h0005, 1'b1, "R2 pfx1 post1");
      write_word(16'h0208, 1'b0, "R3 legal hs stop");
      expect_out(16, 0, 16'h0208, 1'b0, "R3 pfx2 post0");
      write_word(16'h0211, 1'b0, "R1 write max ratio");
      expect_out(2, 0, 16'h0211, 1'b0, "R1 pfx4 post1");

      write_word(16'h000C, 1'b1, "R3 missing hs stop");
      write_word(16'h0015, 1'b1, "R4 prefix 5");
      write_word(16'h0002, 1'b1, "R4 post code 2");
      write_word(16'h0100, 1'b1, "R3 card stop only");
      expect_out(2, 0, 16'h0211, 1'b0, "R4 rejected writes kept");

      pulse(1'b1, 16'h0311, "R5 disable word");
      expect_out(0, 0, 16'h0311, 1'b0, "R5 disabled");
      pulse(1'b0, 16'h0211, "R6 enable word");
      expect_out(2, 0, 16'h0211, 1'b0, "R6 enabled pfx4");

      write_word(16'h0005, 1'b0, "R6 write 0x005");
      pulse(1'b1, 16'h0305, "R5 disable pfx1");
      pulse(1'b0, 16'h0005, "R6 enable pfx1");
      expect_out(16, 64, 16'h0005, 1'b1, "R6 restored pfx1");

      write_word(16'h0300, 1'b0, "R5 stopped word");
      expect_out(0, 0, 16'h0300, 1'b0, "R5 stopped outputs");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule